// File: doc/BRIEF.md
# Data Weighted Averaging Element Selector

This block sits between the digital loop of a multi-bit oversampling converter and its array of matched unit elements, whose outputs are summed. Each sample it takes a code and turns on exactly that many of the 2^B elements. It does not always turn on the same low-order elements. Each run of enabled elements begins where the previous run ended and wraps from the top of the array back to element 0. Every element is therefore used as often as any other, and the mismatch between elements averages out over time.

The code input is B+1 bits wide so that full scale (all 2^B elements) can be requested. Codes above full scale saturate to full scale. A rotation pointer of B bits holds the first element of the next run. It moves only on valid samples and returns to 0 on reset. The enables are registered and appear one clock after the sample is accepted.

Top module: `dwa_selector`

## Requirements
- R1: A synchronous active-low reset clears all enables and `out_valid`. The first valid sample after reset starts its run at element 0.
- R2: One cycle after a valid sample, the number of asserted bits of `elem_en` equals min(`in_code`, 2^B).
- R3: The enabled elements form one run of consecutive indices. The run starts at the pointer and climbs upward, wrapping from element 2^B-1 to element 0. Bit i of `elem_en` drives element i.
- R4: After each valid sample, the pointer advances by the saturated count, modulo 2^B.
- R5: A code of 0 enables no element and leaves the pointer where it was.
- R6: A code of 2^B enables every element and leaves the pointer in place. Any code above 2^B behaves exactly like 2^B.
- R7: When `in_valid` is low, `elem_en` is all zero on the next cycle, `out_valid` is low, and the pointer holds its value.
- R8: `out_valid` is `in_valid` delayed by one clock.
- R9: Two consecutive valid samples whose counts total at most 2^B enable disjoint groups of elements. Since reset, the cumulative usage counts of any two elements never differ by more than one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | High when `in_code` carries a sample |
| in_code | input | B+1 | Number of elements to enable; saturates at 2^B |
| elem_en | output | 2^B | Registered unit-element enables, bit i for element i |
| out_valid | output | 1 | High when `elem_en` holds a sample's selection |

## Verification
The bound checker verifies several properties on every cycle. The enable count matches the saturated code of the previous sample. Idle cycles produce an empty output with `out_valid` low. `out_valid` tracks `in_valid` one clock later. Back-to-back valid samples that fit in the array never share an element.

The pointer's exact position cannot be seen at the ports, so only the bench's scenarios can show it. The bench compares the exact run position, the wrap at the top of the array, the pointer being held across zero codes, full-scale codes and idle cycles, and the restart at element 0 after reset against its own model. It also tracks the long-run usage balance across thousands of random samples.

// File: rtl/dwa_pkg.sv
// Package: shared defaults for the data weighted averaging selector.
// Assumes a power-of-two element array sized by the code width.
package dwa_pkg;
    // Default code width B; the array holds 2^B unit elements.
    localparam int unsigned DWA_CODE_W_DEF = 3;
endpackage

// File: rtl/dwa_thermo.sv
// dwa_thermo: saturates the incoming code to the array size and expands it
// into a thermometer word anchored at bit 0. It also returns the pointer step,
// which is the saturated count modulo the array size.
// Assumes CODE_W >= 1 and an input one bit wider than CODE_W.
module dwa_thermo #(
    parameter int unsigned CODE_W = dwa_pkg::DWA_CODE_W_DEF
) (
    input  logic [CODE_W:0]          code,
    output logic [(1<<CODE_W)-1:0]   therm,
    output logic [CODE_W-1:0]        step
);
    localparam int unsigned N_ELEM = 1 << CODE_W;
    localparam logic [CODE_W:0] FULL = {1'b1, {CODE_W{1'b0}}};

    logic [CODE_W:0] sat;

    // Clamp codes above full scale to full scale.
    always_comb begin
        sat = (code > FULL) ? FULL : code;
    end

    // Full scale wraps to a step of zero, so the pointer stays put.
    assign step = sat[CODE_W-1:0];

    // One comparator per element: element i is on when i < saturated count.
    for (genvar i = 0; i < N_ELEM; i++) begin : g_cmp
        localparam logic [CODE_W:0] IDX = (CODE_W+1)'(i);
        assign therm[i] = (IDX < sat);
    end
endmodule

// File: rtl/dwa_rotator.sv
// dwa_rotator: logarithmic barrel rotator. It moves bit i of the input to
// bit (i + amt) mod 2^CODE_W of the output.
// Assumes the word width is exactly 2^CODE_W.
module dwa_rotator #(
    parameter int unsigned CODE_W = dwa_pkg::DWA_CODE_W_DEF
) (
    input  logic [(1<<CODE_W)-1:0] din,
    input  logic [CODE_W-1:0]      amt,
    output logic [(1<<CODE_W)-1:0] dout
);
    localparam int unsigned N_ELEM = 1 << CODE_W;

    logic [N_ELEM-1:0] stage [0:CODE_W];

    assign stage[0] = din;

    // One stage per bit of the amount: rotate left by 2^s when bit s is set.
    for (genvar s = 0; s < CODE_W; s++) begin : g_stage
        localparam int unsigned SH = 1 << s;
        assign stage[s+1] = amt[s]
            ? ((stage[s] << SH) | (stage[s] >> (N_ELEM - SH)))
            : stage[s];
    end

    assign dout = stage[CODE_W];
endmodule

// File: rtl/dwa_pointer.sv
// dwa_pointer: holds the index of the first element of the next run.
// It advances by the step on each accepted sample; the B-bit wrap gives the
// modulo. Assumes step already equals the saturated count mod 2^CODE_W.
module dwa_pointer #(
    parameter int unsigned CODE_W = dwa_pkg::DWA_CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [CODE_W-1:0] step,
    output logic [CODE_W-1:0] ptr
);
    // Pointer register: clear on reset, advance on accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= ptr + step;
        end
    end
endmodule

// File: rtl/dwa_selector.sv
// dwa_selector: data weighted averaging selector for a 2^CODE_W element array.
// Each valid sample enables min(code, 2^CODE_W) consecutive elements, starting
// at the rotation pointer and wrapping around the array. Enables are registered.
// Assumes a single clock and a synchronous active-low reset.
module dwa_selector #(
    parameter int unsigned CODE_W = dwa_pkg::DWA_CODE_W_DEF,
    localparam int unsigned N_ELEM = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CODE_W:0]   in_code,
    output logic [N_ELEM-1:0] elem_en,
    output logic              out_valid
);
    logic [N_ELEM-1:0] therm;
    logic [N_ELEM-1:0] rotated;
    logic [CODE_W-1:0] step;
    logic [CODE_W-1:0] ptr;

    dwa_thermo #(.CODE_W(CODE_W)) u_thermo (
        .code  (in_code),
        .therm (therm),
        .step  (step)
    );

    dwa_rotator #(.CODE_W(CODE_W)) u_rot (
        .din  (therm),
        .amt  (ptr),
        .dout (rotated)
    );

    dwa_pointer #(.CODE_W(CODE_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_valid),
        .step  (step),
        .ptr   (ptr)
    );

    // Output register: capture the rotated selection, or clear it when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elem_en   <= '0;
            out_valid <= 1'b0;
        end else begin
            elem_en   <= in_valid ? rotated : '0;
            out_valid <= in_valid;
        end
    end
endmodule

// File: rtl/dwa_selector_chk.sv
// dwa_selector_chk: protocol checker bound to dwa_selector. It observes only
// the ports and keeps the last valid selection to check for overlap.
module dwa_selector_chk #(
    parameter int unsigned CODE_W = dwa_pkg::DWA_CODE_W_DEF,
    localparam int unsigned N_ELEM = 1 << CODE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [CODE_W:0]   in_code,
    input logic [N_ELEM-1:0] elem_en,
    input logic              out_valid
);
    localparam logic [CODE_W:0] FULL = {1'b1, {CODE_W{1'b0}}};

    logic [CODE_W:0]   sat_code;
    logic [N_ELEM-1:0] last_en;
    logic              have_last;

    // Saturated request, used one cycle later through $past.
    assign sat_code = (in_code > FULL) ? FULL : in_code;

    // Remember the most recent valid selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_en   <= '0;
            have_last <= 1'b0;
        end else if (out_valid) begin
            last_en   <= elem_en;
            have_last <= 1'b1;
        end
    end

    // R2
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid)) |->
            ($countones(elem_en) == int'($past(sat_code))));

    // R7
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> (elem_en == '0 && !out_valid));

    // R8
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && have_last &&
         ($countones(elem_en) + $countones(last_en) <= N_ELEM)) |->
            ((elem_en & last_en) == '0));
endmodule

bind dwa_selector dwa_selector_chk #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_code   (in_code),
    .elem_en   (elem_en),
    .out_valid (out_valid)
);

// File: tb/test_dwa_selector.sv
module test_dwa_selector;
    localparam int unsigned CODE_W = 3;
    localparam int unsigned N = 1 << CODE_W;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [CODE_W:0] in_code = '0;
    logic [N-1:0]  elem_en;
    logic          out_valid;

    int checks = 0;
    int fails  = 0;
    int mptr   = 0;
    int usage [N];

    dwa_selector #(.CODE_W(CODE_W)) i_dwa_selector (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
        .elem_en(elem_en), .out_valid(out_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected run of cnt elements starting at p, wrapping at N.
    function automatic logic [N-1:0] exp_run(int p, int cnt);
        logic [N-1:0] e = '0;
        for (int k = 0; k < cnt; k++) e[(p + k) % N] = 1'b1;
        return e;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_usage();
        for (int i = 0; i < N; i++) usage[i] = 0;
    endtask

    // Apply one cycle of input at a negedge; check outputs at the next negedge.
    task automatic step(bit v, int code, string req);
        int cnt;
        logic [N-1:0] e;
        int mx, mn;
        in_valid = v;
        in_code  = code[CODE_W:0];
        cnt = (code > int'(N)) ? int'(N) : code;
        e = v ? exp_run(mptr, cnt) : '0;
        if (v) mptr = (mptr + cnt) % N;
        @(negedge clk);
        check(elem_en === e, req, 32'(elem_en), 32'(e));
        check(out_valid === v, "R8", 32'(out_valid), 32'(v));
        if (v) begin
            mx = 0; mn = 1 << 30;
            for (int i = 0; i < N; i++) begin
                usage[i] += int'(elem_en[i]);
                if (usage[i] > mx) mx = usage[i];
                if (usage[i] < mn) mn = usage[i];
            end
            check((mx - mn) <= 1, "R9 usage balance", 32'(mx - mn), 32'd1);
        end
    endtask

    task automatic do_reset(bit v_during);
        rst_n = 1'b0;
        in_valid = v_during;
        in_code = 4'd5;
        @(negedge clk);
        @(negedge clk);
        check(elem_en === '0, "R1 reset enables", 32'(elem_en), 32'd0);
        check(out_valid === 1'b0, "R1 reset valid", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        mptr = 0;
        clear_usage();
    endtask

    initial begin
        void'($urandom(32'd20061214));
        clear_usage();
        @(negedge clk);
        do_reset(1'b0);
        // R1: first run starts at element 0
        step(1, 3, "R1 first run");
        // R3 / R9: 2, then 4, then 3 elements in consecutive disjoint groups
        do_reset(1'b0);
        step(1, 2, "R3 run 2");
        check(elem_en === 8'b0000_0011, "R3 exact", 32'(elem_en), 32'h03);
        step(1, 4, "R3 run 4");
        check(elem_en === 8'b0011_1100, "R3 exact", 32'(elem_en), 32'h3C);
        step(1, 3, "R3 wrap");
        check(elem_en === 8'b1100_0001, "R3 wrap exact", 32'(elem_en), 32'hC1);
        // R5: zero code, pointer held (next run starts at 1)
        step(1, 0, "R5 zero code");
        step(1, 2, "R5 pointer held");
        check(elem_en === 8'b0000_0110, "R5 exact", 32'(elem_en), 32'h06);
        // R6: full scale and saturation, pointer held
        step(1, 8, "R6 full scale");
        step(1, 15, "R6 saturate");
        step(1, 9, "R6 saturate");
        step(1, 1, "R6 pointer held");
        check(elem_en === 8'b0000_1000, "R6 exact", 32'(elem_en), 32'h08);
        // R7: idle cycles hold the pointer
        step(0, 5, "R7 idle");
        step(0, 7, "R7 idle");
        step(1, 5, "R7 pointer after idle");
        // R4: large steps wrapping the pointer
        step(1, 7, "R4 step 7");
        step(1, 6, "R4 step 6");
        // R1: reset mid-run with valid held high
        do_reset(1'b1);
        step(1, 1, "R1 restart at 0");
        check(elem_en === 8'b0000_0001, "R1 exact", 32'(elem_en), 32'h01);
        // Random traffic: R2, R3, R4, R7, R9
        for (int n = 0; n < 3000; n++) begin
            bit v;
            int c;
            v = ($urandom % 5) != 0;
            c = int'($urandom % 11);
            if (c > 15) c = 15;
            step(v, c, "R2 R4 random");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule